// File: doc/BRIEF.md
# Receive Buffer Resource Ring Fetcher

This block keeps the receive path supplied with buffers. Software places buffer descriptors in a circular area of memory, bounded by a start pointer and an end pointer. A write pointer, owned by software, marks how far the area has been filled. On each trigger the block reads one descriptor at the current read pointer. A descriptor is four 16-bit fields: the buffer base address (low half, then high half) and the buffer word count (low half, then high half). The block loads those fields into its working registers. It then advances the read pointer, wrapping at the end pointer, and raises an exhausted flag when the read pointer reaches the write pointer.

A fetch can be started in three ways: by a command pulse, by software clearing the exhausted flag, or by the receive path. The receive path reports each stored frame together with its byte length. The block subtracts the frame's word cost from the remaining word count. When the result falls below a programmable low-water count, the block raises a last-packet flag and fetches the next buffer on its own.

Descriptor reads go out one at a time on a simple request/valid memory port. The upper 16 address bits come from a shared upper-address input, and the lower 16 bits from the read pointer plus the field offset. Fields are 2 bytes apart in 16-bit mode and 4 bytes apart in 32-bit mode.

Top module: `rx_ring_fetcher`

## Requirements
- R1: After reset, busy, memory request, exhausted, command bit, last-packet flag, read pointer, buffer address and word count are all zero, and rx ready is high.
- R2: A fetch issues exactly four reads in a fixed order: base low, base high, count low, count high. The address of field k is {upper_addr_i, read pointer} + k*2 in 16-bit mode and + k*4 in 32-bit mode (wide_mode_i = 1).
- R3: When the fourth read completes, buf_addr_o becomes {base high, base low} and buf_wc_o becomes {count high, count low}.
- R4: On completion, the read pointer advances by 8 bytes (16-bit mode) or 16 bytes (32-bit mode). If the advanced value equals the end pointer, it is replaced by the start pointer.
- R5: If the updated read pointer equals the write pointer, exhausted_o is set and stays set until it is cleared. While exhausted_o is set, rx_ready_o is low.
- R6: An exh_clear_i pulse while exhausted_o is set clears the flag and starts a fetch. A pulse while the flag is clear changes nothing and starts no fetch.
- R7: A frame_done_i pulse reduces buf_wc_o by (frame_len_i + 4) / 2, rounded down. last_pkt_o takes the value of (new count < eob_count_i). When that value is true, a fetch is started.
- R8: fetch_cmd_o is set by a fetch_cmd_i pulse and is cleared when a fetch completes.
- R9: A trigger that arrives while a fetch is running is held, and one further fetch runs after the current one.
- R10: busy_o rises together with the first memory request and stays high until the cycle in which the working registers load.
- R11: Bit 0 of the start, end, write and loaded read pointers is treated as zero. All pointer comparisons are full 16-bit equality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_mode_i | input | 1 | 1 selects 32-bit descriptor layout |
| upper_addr_i | input | 16 | Address bits 31:16 for descriptor reads |
| ring_start_i | input | 16 | Ring start pointer |
| ring_end_i | input | 16 | Ring end pointer |
| ring_wr_i | input | 16 | Software write pointer |
| rd_load_i | input | 1 | Load the read pointer |
| rd_load_val_i | input | 16 | Value for read pointer load |
| fetch_cmd_i | input | 1 | Fetch command pulse |
| exh_clear_i | input | 1 | Write-one-to-clear pulse for the exhausted flag |
| frame_done_i | input | 1 | A frame was stored in the current buffer |
| frame_len_i | input | 16 | Byte length of that frame |
| eob_count_i | input | 16 | Low-water word count |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | Fetch in progress |
| fetch_cmd_o | output | 1 | Fetch command bit |
| exhausted_o | output | 1 | Resources exhausted flag |
| rx_ready_o | output | 1 | Receiver may accept frames |
| buf_addr_o | output | 32 | Current buffer address |
| buf_wc_o | output | 32 | Remaining buffer word count |
| rd_ptr_o | output | 16 | Ring read pointer |
| last_pkt_o | output | 1 | Buffer fell below the low-water count |

## Verification
A trigger is sampled at one clock edge and sets a pending bit; the fetch starts at the next edge, so busy_o is first seen high at the second sampling point after the trigger is driven. With a responder that waits L cycles before each valid, busy_o stays high for exactly 4L+7 sampling points. The working registers, read pointer and exhausted flag are read at the first sampling point where busy_o is low again. A frame pulse is accounted at the edge that samples it, so count and flag are read at the next sampling point; negative cases watch busy_o over several idle cycles to confirm that no fetch started.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int FIELD_CNT = 4;

  typedef enum logic {SEQ_IDLE, SEQ_READ} seq_state_e;

  // bytes occupied by one descriptor
  function automatic logic [15:0] ring_step(input logic wide);
    return wide ? 16'(FIELD_CNT * 4) : 16'(FIELD_CNT * 2);
  endfunction
endpackage

// File: rtl/rrf_fetch_seq.sv
module rrf_fetch_seq
  import rrf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int NF = FIELD_CNT
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           wide_i,
  input  logic [AW-1:0]  base_i,
  input  logic           mem_rvalid_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           busy_o,
  output logic           done_o,
  output logic [NF*DW-1:0] fields_o
);
  localparam int IW = $clog2(NF);

  seq_state_e             st_q;
  logic [IW-1:0]          idx_q;
  logic [NF-2:0][DW-1:0]  cap_q;
  logic                   last_field;

  assign last_field = (idx_q == IW'(NF - 1));
  assign mem_req_o  = (st_q == SEQ_READ);
  assign busy_o     = mem_req_o;
  assign done_o     = mem_req_o & mem_rvalid_i & last_field;
  assign mem_addr_o = base_i + (AW'(idx_q) << (wide_i ? 2 : 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
      cap_q <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: if (start_i) begin
          st_q  <= SEQ_READ;
          idx_q <= '0;
        end
        default: if (mem_rvalid_i) begin
          if (last_field) begin
            st_q <= SEQ_IDLE;
          end else begin
            cap_q[idx_q] <= mem_rdata_i;
            idx_q        <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  // last field is forwarded straight from the bus on the completing beat
  for (genvar g = 0; g < NF - 1; g++) begin : g_fld
    assign fields_o[g*DW +: DW] = cap_q[g];
  end
  assign fields_o[(NF-1)*DW +: DW] = mem_rdata_i;

  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  a_r2_first_at_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_addr_o == base_i);
endmodule

// File: rtl/rrf_ptr_unit.sv
module rrf_ptr_unit
  import rrf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wide_i,
  input  logic         done_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  input  logic [W-1:0] wr_i,
  input  logic         exh_clr_i,
  output logic [W-1:0] rd_o,
  output logic         exhausted_o,
  output logic         exh_ack_o
);
  localparam logic [W-1:0] EVEN = ~W'(1);

  logic [W-1:0] rd_q, adv, nxt;
  logic         exh_q;

  assign adv = rd_q + W'(ring_step(wide_i));
  assign nxt = (adv == (end_i & EVEN)) ? (start_i & EVEN) : adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      exh_q <= 1'b0;
    end else begin
      if (done_i)      rd_q <= nxt;
      else if (load_i) rd_q <= load_val_i & EVEN;
      if (done_i && (nxt == (wr_i & EVEN))) exh_q <= 1'b1;
      else if (exh_clr_i)                   exh_q <= 1'b0;
    end
  end

  assign rd_o        = rd_q;
  assign exhausted_o = exh_q;
  assign exh_ack_o   = exh_clr_i & exh_q;

  a_r11_ptr_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q[0]);
  a_r6_clear_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exh_clr_i && !done_i |=> !exhausted_o);
endmodule

// File: rtl/rrf_wc_track.sv
module rrf_wc_track #(
  parameter int W  = 16,
  parameter int NF = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic [NF*W-1:0] fields_i,
  input  logic            frame_done_i,
  input  logic [W-1:0]    frame_len_i,
  input  logic [W-1:0]    eob_i,
  output logic [2*W-1:0]  buf_addr_o,
  output logic [2*W-1:0]  buf_wc_o,
  output logic            last_pkt_o,
  output logic            low_trig_o
);
  localparam int AW = 2 * W;

  logic [AW-1:0] addr_q, wc_q, cost, wc_n;
  logic          last_q, low;

  // frame bytes plus 4 CRC bytes, in 16-bit words
  assign cost = (AW'(frame_len_i) + AW'(4)) >> 1;
  assign wc_n = wc_q - cost;
  assign low  = wc_n < AW'(eob_i);
  assign low_trig_o = frame_done_i & ~done_i & low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wc_q   <= '0;
      last_q <= 1'b0;
    end else if (done_i) begin
      addr_q <= fields_i[AW-1:0];
      wc_q   <= fields_i[2*AW-1:AW];
    end else if (frame_done_i) begin
      wc_q   <= wc_n;
      last_q <= low;
    end
  end

  assign buf_addr_o = addr_q;
  assign buf_wc_o   = wc_q;
  assign last_pkt_o = last_q;

  a_r7_low_sets_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_trig_o |=> last_pkt_o);
endmodule

// File: rtl/rx_ring_fetcher.sv
module rx_ring_fetcher
  import rrf_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wide_mode_i,
  input  logic [PTR_W-1:0]   upper_addr_i,
  input  logic [PTR_W-1:0]   ring_start_i,
  input  logic [PTR_W-1:0]   ring_end_i,
  input  logic [PTR_W-1:0]   ring_wr_i,
  input  logic               rd_load_i,
  input  logic [PTR_W-1:0]   rd_load_val_i,
  input  logic               fetch_cmd_i,
  input  logic               exh_clear_i,
  input  logic               frame_done_i,
  input  logic [PTR_W-1:0]   frame_len_i,
  input  logic [PTR_W-1:0]   eob_count_i,
  output logic               mem_req_o,
  output logic [2*PTR_W-1:0] mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [PTR_W-1:0]   mem_rdata_i,
  output logic               busy_o,
  output logic               fetch_cmd_o,
  output logic               exhausted_o,
  output logic               rx_ready_o,
  output logic [2*PTR_W-1:0] buf_addr_o,
  output logic [2*PTR_W-1:0] buf_wc_o,
  output logic [PTR_W-1:0]   rd_ptr_o,
  output logic               last_pkt_o
);
  localparam int AW = 2 * PTR_W;

  logic                      done, start, trig, exh_ack, low_trig;
  logic                      pend_q, cmd_q;
  logic [FIELD_CNT*PTR_W-1:0] fields;

  assign trig  = fetch_cmd_i | exh_ack | low_trig;
  assign start = pend_q & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cmd_q  <= 1'b0;
    end else begin
      pend_q <= start ? trig : (pend_q | trig);
      if (fetch_cmd_i) cmd_q <= 1'b1;
      else if (done)   cmd_q <= 1'b0;
    end
  end

  rrf_fetch_seq #(.AW(AW), .DW(PTR_W), .NF(FIELD_CNT)) u_seq (
    .clk_i, .rst_ni,
    .start_i      (start),
    .wide_i       (wide_mode_i),
    .base_i       ({upper_addr_i, rd_ptr_o}),
    .mem_rvalid_i, .mem_rdata_i, .mem_req_o, .mem_addr_o,
    .busy_o,
    .done_o       (done),
    .fields_o     (fields)
  );

  rrf_ptr_unit #(.W(PTR_W)) u_ptr (
    .clk_i, .rst_ni,
    .wide_i      (wide_mode_i),
    .done_i      (done),
    .load_i      (rd_load_i),
    .load_val_i  (rd_load_val_i),
    .start_i     (ring_start_i),
    .end_i       (ring_end_i),
    .wr_i        (ring_wr_i),
    .exh_clr_i   (exh_clear_i),
    .rd_o        (rd_ptr_o),
    .exhausted_o,
    .exh_ack_o   (exh_ack)
  );

  rrf_wc_track #(.W(PTR_W), .NF(FIELD_CNT)) u_wc (
    .clk_i, .rst_ni,
    .done_i       (done),
    .fields_i     (fields),
    .frame_done_i, .frame_len_i,
    .eob_i        (eob_count_i),
    .buf_addr_o, .buf_wc_o, .last_pkt_o,
    .low_trig_o   (low_trig)
  );

  assign fetch_cmd_o = cmd_q;
  assign rx_ready_o  = ~exhausted_o;

  a_r9_trigger_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig && busy_o |=> pend_q);
  a_r8_cmd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !fetch_cmd_i |=> !fetch_cmd_o);
endmodule

// File: tb/rx_ring_fetcher_tb.sv
module rx_ring_fetcher_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide = 1'b0, rd_load = 1'b0, fetch_cmd = 1'b0, exh_clear = 1'b0, frame_done = 1'b0;
  logic [15:0] upper = '0, r_start = '0, r_end = '0, r_wr = '0, rd_val = '0, f_len = '0, eobc = '0;
  logic mem_req, mem_rvalid = 1'b0, busy, cmd_bit, exh, rx_ready, last_pkt;
  logic [31:0] mem_addr, buf_addr, buf_wc;
  logic [15:0] mem_rdata = '0, rd_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_fetcher dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wide_mode_i(wide), .upper_addr_i(upper),
    .ring_start_i(r_start), .ring_end_i(r_end), .ring_wr_i(r_wr),
    .rd_load_i(rd_load), .rd_load_val_i(rd_val), .fetch_cmd_i(fetch_cmd),
    .exh_clear_i(exh_clear), .frame_done_i(frame_done), .frame_len_i(f_len),
    .eob_count_i(eobc), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .fetch_cmd_o(cmd_bit), .exhausted_o(exh), .rx_ready_o(rx_ready),
    .buf_addr_o(buf_addr), .buf_wc_o(buf_wc), .rd_ptr_o(rd_ptr), .last_pkt_o(last_pkt)
  );

  int checks = 0, errors = 0, lat = 0, mcnt = 0, got_n = 0, exp_n = 0, log_chk = 0;
  logic [31:0] got_log [0:255];
  logic [31:0] exp_log [0:255];
  logic [31:0] exp_addr, exp_wc;
  logic [15:0] exp_rd;
  logic        exp_exh;
  bit          done_flag = 0;

  function automatic logic [15:0] memf(input logic [31:0] a);
    return 16'(a[15:0] * 3) ^ a[31:16] ^ 16'h5A5A;
  endfunction

  // memory responder: waits lat cycles, then one valid beat
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 1'b0;
    else if (mem_req) begin
      if (mcnt >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(mem_addr);
        got_log[got_n % 256] = mem_addr;
        got_n++;
        mcnt = 0;
      end else mcnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_fetch();
    logic [15:0] f [4];
    logic [31:0] a;
    logic [15:0] nxt;
    for (int k = 0; k < 4; k++) begin
      a = {upper, exp_rd} + 32'(k * (wide ? 4 : 2));
      f[k] = memf(a);
      exp_log[exp_n % 256] = a;
      exp_n++;
    end
    exp_addr = {f[1], f[0]};
    exp_wc   = {f[3], f[2]};
    nxt = exp_rd + (wide ? 16'd16 : 16'd8);
    if (nxt == (r_end & 16'hFFFE)) nxt = r_start & 16'hFFFE;
    exp_rd = nxt;
    if (nxt == (r_wr & 16'hFFFE)) exp_exh = 1'b1;
  endtask

  task automatic check_state();
    chk("R3 buffer address", buf_addr, exp_addr);
    chk("R3 word count", buf_wc, exp_wc);
    chk("R4 read pointer", 32'(rd_ptr), 32'(exp_rd));
    chk("R5 exhausted", 32'(exh), 32'(exp_exh));
    chk("R5 rx ready", 32'(rx_ready), 32'(!exp_exh));
    chk("R2 read count", 32'(got_n), 32'(exp_n));
    for (int i = log_chk; i < exp_n && i < got_n; i++)
      chk("R2 field address", got_log[i % 256], exp_log[i % 256]);
    log_chk = exp_n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_addr = '0; exp_wc = '0; exp_rd = '0; exp_exh = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_rd(input logic [15:0] v);
    rd_val = v; rd_load = 1'b1;
    @(negedge clk);
    rd_load = 1'b0;
    exp_rd = v & 16'hFFFE;
  endtask

  task automatic wait_quiet(output bit saw);
    int q = 0;
    saw = 0;
    for (int g = 0; g < 5000 && q < 4; g++) begin
      @(negedge clk);
      if (busy) begin saw = 1; q = 0; end
      else q++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit saw;
    int n;
    logic [15:0] step, base;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 busy", 32'(busy), 0);
    chk("R1 request", 32'(mem_req), 0);
    chk("R1 exhausted", 32'(exh), 0);
    chk("R1 rx ready", 32'(rx_ready), 1);
    chk("R1 command bit", 32'(cmd_bit), 0);
    chk("R1 last packet", 32'(last_pkt), 0);
    chk("R1 read pointer", 32'(rd_ptr), 0);
    chk("R1 buffer address", buf_addr, 0);
    chk("R1 word count", buf_wc, 0);

    // sweep: both layouts, three response latencies, ring of 3 descriptors
    for (int w = 0; w < 2; w++) begin
      for (int l = 0; l < 3; l++) begin
        do_reset();
        wide = w[0]; lat = l;
        step = wide ? 16'd16 : 16'd8;
        base = 16'h0100 + 16'(l * 16'h40);
        upper = 16'h1234 + 16'(w);
        r_start = base | 16'h1;           // R11 odd inputs
        r_end   = (base + 3 * step) | 16'h1;
        r_wr    = (base + 2 * step) | 16'h1;
        load_rd(base | 16'h1);
        chk("R11 loaded pointer even", 32'(rd_ptr), 32'(base));
        for (int f = 0; f < 5; f++) begin
          fetch_cmd = 1'b1;
          @(negedge clk);
          fetch_cmd = 1'b0;
          @(negedge clk);
          chk("R10 busy with first request", 32'({busy, mem_req}), 32'h3);
          chk("R8 command bit set", 32'(cmd_bit), 1);
          n = 0;
          while (busy && n < 1000) begin n++; @(negedge clk); end
          chk("R10 busy length", 32'(n), 32'(4 * l + 7));
          model_fetch();
          chk("R8 command bit cleared", 32'(cmd_bit), 0);
          check_state();
        end
      end
    end

    // R9: second trigger during a running fetch
    do_reset();
    wide = 1'b0; lat = 1; upper = 16'h00A0;
    r_start = 16'h0200; r_end = 16'h0300; r_wr = 16'h0001;
    load_rd(16'h0200);
    fetch_cmd = 1'b1; @(negedge clk); fetch_cmd = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 first fetch running", 32'(busy), 1);
    fetch_cmd = 1'b1; @(negedge clk); fetch_cmd = 1'b0;
    wait_quiet(saw);
    model_fetch(); model_fetch();
    check_state();   // R9 eight reads, two advances

    // R5/R6: exhaust, then clear by write-one
    r_wr = exp_rd + 16'd8;
    fetch_cmd = 1'b1; @(negedge clk); fetch_cmd = 1'b0;
    wait_quiet(saw);
    model_fetch();
    check_state();
    chk("R5 exhausted reached", 32'(exh), 1);
    exh_clear = 1'b1; @(negedge clk); exh_clear = 1'b0;
    chk("R6 flag cleared", 32'(exh), 0);
    wait_quiet(saw);
    chk("R6 clear started fetch", 32'(saw), 1);
    exp_exh = 1'b0;
    model_fetch();
    check_state();
    exh_clear = 1'b1; @(negedge clk); exh_clear = 1'b0;
    wait_quiet(saw);
    chk("R6 clear while clear starts no fetch", 32'(saw), 0);
    check_state();

    // R7: frame accounting and low-water refetch
    do_reset();
    wide = 1'b0; lat = 0;
    r_start = 16'h0400; r_end = 16'h0800; r_wr = 16'h0001;
    upper = 16'(16'h0406 * 3) ^ 16'h5A5A;   // count high field reads as zero
    load_rd(16'h0400);
    fetch_cmd = 1'b1; @(negedge clk); fetch_cmd = 1'b0;
    wait_quiet(saw);
    model_fetch();
    check_state();
    eobc = 16'd0; f_len = 16'd10;
    frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    exp_wc = exp_wc - 32'd7;
    chk("R7 count reduced", buf_wc, exp_wc);
    chk("R7 last packet low", 32'(last_pkt), 0);
    wait_quiet(saw);
    chk("R7 no fetch above low-water", 32'(saw), 0);
    eobc = 16'(exp_wc) - 16'd2; f_len = 16'd4;
    frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    chk("R7 count reduced below low-water", buf_wc, exp_wc - 32'd4);
    chk("R7 last packet set", 32'(last_pkt), 1);
    wait_quiet(saw);
    chk("R7 low-water fetch started", 32'(saw), 1);
    model_fetch();
    check_state();
    chk("R7 last packet held", 32'(last_pkt), 1);

    // R11: odd load value
    load_rd(16'h0457);
    chk("R11 odd load masked", 32'(rd_ptr), 32'h0456);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule